// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block holds the digital sequencing of a 16-bit successive approximation converter whose DAC is a pair of identical binary-weighted capacitor arrays, one per differential input. Both arrays share one switch vector. When idle the block tracks the input:
- The sampling switches that ground the array top plates are closed.
- Every bit switch sits on the analog input.
- A power-down flag is raised.

A falling edge on the active-low conversion request ends tracking and starts a conversion:
- In the first cycle the sampling switches open while the bit switches stay on the inputs. This is the settling cycle.
- The bit switches then leave the inputs. For each of sixteen trials, one per clock, the block drives a grounded/reference pattern and reads a single comparator decision. The trials run from the heaviest bit down.
- After the lightest bit is decided, the block returns to tracking.
- In that same cycle it presents the straight-binary code together with a one-cycle completion pulse. There is no extra latency.

The comparator itself, the capacitor arrays, the reference and any serial readout are outside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After synchronous reset the outputs are as follows: `samp_sw_closed`=1, `arr_on_input`=1, `bit_sw_ref`=0, `busy`=0, `done`=0, `pwr_down`=1, `result`=0.
- R2: A clock edge that sees `conv_req_n` low, after it was sampled high at the previous edge, starts a conversion while idle. In the next cycle `busy`=1, `samp_sw_closed`=0, `arr_on_input`=1 and `bit_sw_ref`=0. This is the settling cycle.
- R3: In the k-th cycle after the settling cycle (k=1..16), `arr_on_input`=0. `bit_sw_ref` equals the bits already kept, OR a single 1 at bit position 16-k. The first trial is therefore 0x8000, and each later trial weight is half the one before it.
- R4: A `cmp_above` value of 1 at the end of a trial cycle keeps that trial bit, and 0 clears it. With an ideal comparator (1 when the input code is at or above the trial value), `result` equals the input code. The code is straight binary: 0x0000 at the bottom of the range, 0x8000 at midscale, 0xFFFF at full scale.
- R5: `done` is a one-cycle pulse in the cycle right after the last trial, which is 17 edges after the starting edge. In that cycle `result` already holds the new code, `samp_sw_closed`=1 and `arr_on_input`=1.
- R6: `busy` is high for exactly 17 cycles per conversion: the settling cycle plus 16 trials. It falls in the cycle where `done` rises.
- R7: A falling edge of `conv_req_n` while `busy` is high is ignored. The conversion timing and code are unchanged.
- R8: With `cmp_above` stuck at 1 the result is 0xFFFF (overrange). With it stuck at 0 the result is 0x0000 (underrange).
- R9: `pwr_down` is high whenever no conversion is in progress, and low while `busy` is high.
- R10: `result` holds its value between completion pulses.
- R11: Holding `conv_req_n` low after a conversion does not start another one. A new high-then-low transition is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_req_n | input | 1 | Active-low conversion request; its falling edge starts a conversion |
| cmp_above | input | 1 | Comparator decision, 1 when the held input is at or above the trial level |
| samp_sw_closed | output | 1 | 1 closes the switches that tie both array top plates to ground |
| arr_on_input | output | 1 | 1 connects all bit switches of both arrays to the analog inputs |
| bit_sw_ref | output | 16 | Per-bit switch vector when off the inputs: 1 = reference, 0 = ground |
| busy | output | 1 | Conversion in progress |
| pwr_down | output | 1 | Converter powered down (idle/tracking) |
| done | output | 1 | One-cycle pulse when a new code is presented |
| result | output | 16 | Straight-binary conversion code |

## Verification
Codes at midscale, one step below it, both ends of the range, the lowest nonzero code and two scattered patterns are each converted through an ideal comparator. A wrong trial weight, a wrong bit order or a lost keep/clear decision therefore shows up as a wrong code. Stuck-high and stuck-low comparators separate the overrange and underrange ends from the real input. A request toggled in the middle of a conversion, and a request held low afterwards, separate correct edge qualification from a retrigger. A behavioural model compares every output on every clock, so any shift in trial timing or switch phase is caught in the cycle it happens.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        PH_ACQ    = 2'd0,
        PH_SETTLE = 2'd1,
        PH_TRIAL  = 2'd2
    } phase_e;

    typedef struct packed {
        logic samp_closed;
        logic on_input;
        logic busy;
        logic pwr_down;
    } ctrl_flags_t;

    function automatic ctrl_flags_t phase_flags(phase_e ph);
        ctrl_flags_t f;
        case (ph)
            PH_ACQ:    f = '{samp_closed: 1'b1, on_input: 1'b1, busy: 1'b0, pwr_down: 1'b1};
            PH_SETTLE: f = '{samp_closed: 1'b0, on_input: 1'b1, busy: 1'b1, pwr_down: 1'b0};
            default:   f = '{samp_closed: 1'b0, on_input: 1'b0, busy: 1'b1, pwr_down: 1'b0};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    input  logic idle,
    output logic start
);
    logic req_n_q;

    always_ff @(posedge clk) begin
        if (rst) req_n_q <= 1'b1;
        else     req_n_q <= req_n;
    end

    // Falling edge qualified by idle phase; edges during a conversion are dropped
    assign start = idle & req_n_q & ~req_n;
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int NBITS = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    output phase_e                   phase,
    output logic [$clog2(NBITS)-1:0] bit_idx,
    output logic                     trial_en,
    output logic                     last_trial
);
    localparam int CW = $clog2(NBITS);
    localparam logic [CW-1:0] IDX_MSB = CW'(NBITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_ACQ;
            bit_idx <= IDX_MSB;
        end else begin
            case (phase)
                PH_ACQ: begin
                    if (start) phase <= PH_SETTLE;
                end
                PH_SETTLE: begin
                    phase   <= PH_TRIAL;
                    bit_idx <= IDX_MSB;
                end
                default: begin
                    if (bit_idx == '0) phase <= PH_ACQ;
                    else               bit_idx <= bit_idx - 1'b1;
                end
            endcase
        end
    end

    assign trial_en   = (phase == PH_TRIAL);
    assign last_trial = trial_en && (bit_idx == '0);

    // R3: the trial index walks downward one step per trial cycle
    p_idx_steps_down_r3: assert property (@(posedge clk) disable iff (rst)
        (trial_en && bit_idx != '0) |=> (trial_en && bit_idx == $past(bit_idx) - 1'b1));
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int NBITS = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     trial_en,
    input  logic [$clog2(NBITS)-1:0] bit_idx,
    input  logic                     cmp_above,
    output logic [NBITS-1:0]         trial_vec,
    output logic [NBITS-1:0]         acc_next
);
    localparam logic [NBITS-1:0] ONE = NBITS'(1);

    logic [NBITS-1:0] acc;

    assign trial_vec = acc | (ONE << bit_idx);
    assign acc_next  = cmp_above ? trial_vec : acc;

    always_ff @(posedge clk) begin
        if (rst || clear) acc <= '0;
        else if (trial_en) acc <= acc_next;
    end

    // R4: a trial never removes a bit already kept
    p_kept_bits_stay_r4: assert property (@(posedge clk) disable iff (rst)
        (trial_en && !clear) |=> ((acc & $past(acc)) == $past(acc)));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int NBITS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_req_n,
    input  logic             cmp_above,
    output logic             samp_sw_closed,
    output logic             arr_on_input,
    output logic [NBITS-1:0] bit_sw_ref,
    output logic             busy,
    output logic             pwr_down,
    output logic             done,
    output logic [NBITS-1:0] result
);
    localparam int CW = $clog2(NBITS);
    localparam logic [NBITS-1:0] MSB_ONLY = NBITS'(1) << (NBITS - 1);

    phase_e           phase;
    logic [CW-1:0]    bit_idx;
    logic             trial_en, last_trial, start;
    logic [NBITS-1:0] trial_vec, acc_next;
    ctrl_flags_t      flags;

    sar_start_detect u_start (
        .clk   (clk),
        .rst   (rst),
        .req_n (conv_req_n),
        .idle  (phase == PH_ACQ),
        .start (start)
    );

    sar_sequencer #(.NBITS(NBITS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .phase      (phase),
        .bit_idx    (bit_idx),
        .trial_en   (trial_en),
        .last_trial (last_trial)
    );

    sar_approx_reg #(.NBITS(NBITS)) u_sar (
        .clk       (clk),
        .rst       (rst),
        .clear     (start),
        .trial_en  (trial_en),
        .bit_idx   (bit_idx),
        .cmp_above (cmp_above),
        .trial_vec (trial_vec),
        .acc_next  (acc_next)
    );

    assign flags          = phase_flags(phase);
    assign samp_sw_closed = flags.samp_closed;
    assign arr_on_input   = flags.on_input;
    assign busy           = flags.busy;
    assign pwr_down       = flags.pwr_down;
    assign bit_sw_ref     = trial_en ? trial_vec : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= last_trial;
            if (last_trial) result <= acc_next;
        end
    end

    // R2: the edge after a start is the settling cycle
    p_settle_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !samp_sw_closed && arr_on_input && bit_sw_ref == '0));

    // R3: first trial drives only the heaviest bit
    p_msb_first_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SETTLE) |=> (bit_sw_ref == MSB_ONLY && !arr_on_input));

    // R5: completion is a single-cycle pulse that lands back in tracking
    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_tracking_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (samp_sw_closed && arr_on_input && !busy && pwr_down));

    // R7: busy cannot end before the last trial, whatever the request does
    p_busy_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !last_trial) |=> busy);

    // R10: the code only moves on a completion pulse
    p_result_holds_r10: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));
endmodule

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;
    localparam int NB = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          conv_req_n = 1'b1;
    logic          cmp_above;
    logic          samp_sw_closed, arr_on_input, busy, pwr_down, done;
    logic [NB-1:0] bit_sw_ref, result;

    int unsigned vin = 0;
    int          cmode = 0;   // 0 ideal, 1 stuck high, 2 stuck low
    int          vectors = 0;
    int          fails = 0;
    int          cyc = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;     // 125 MHz

    function automatic bit cmp_fn(int unsigned trial);
        if (cmode == 1) return 1'b1;
        if (cmode == 2) return 1'b0;
        return (vin >= trial);
    endfunction

    assign cmp_above = cmp_fn(int'(bit_sw_ref));

    sar_conv_ctrl #(.NBITS(NB)) u_sar_conv_ctrl (
        .clk(clk), .rst(rst), .conv_req_n(conv_req_n), .cmp_above(cmp_above),
        .samp_sw_closed(samp_sw_closed), .arr_on_input(arr_on_input),
        .bit_sw_ref(bit_sw_ref), .busy(busy), .pwr_down(pwr_down),
        .done(done), .result(result)
    );

    // Behavioural reference: m_cnt 0 idle, 1 settling, 2..17 trials
    int          m_cnt = 0;
    int unsigned m_acc = 0, m_res = 0;
    bit          m_done = 0, m_reqq = 1;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_acc = 0; m_res = 0; m_done = 0; m_reqq = 1;
        end else begin
            m_done = 0;
            if (m_cnt == 0) begin
                if (m_reqq && !conv_req_n) begin m_cnt = 1; m_acc = 0; end
            end else if (m_cnt == 1) begin
                m_cnt = 2;
            end else begin
                int unsigned t;
                t = m_acc | (32'd1 << (17 - m_cnt));
                if (cmp_fn(t)) m_acc = t;
                if (m_cnt == 17) begin m_cnt = 0; m_res = m_acc; m_done = 1; end
                else m_cnt++;
            end
            m_reqq = conv_req_n;
        end
    end

    task automatic chk(string tag, string nm, int unsigned got, int unsigned exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%0h expected=%0h (cycle %0d)", tag, nm, got, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            int unsigned eref;
            eref = (m_cnt >= 2) ? (m_acc | (32'd1 << (17 - m_cnt))) : 0;
            chk("R2", "samp_sw_closed", samp_sw_closed, m_cnt == 0);
            chk("R3", "arr_on_input", arr_on_input, m_cnt <= 1);
            chk("R3", "bit_sw_ref", bit_sw_ref, eref);
            chk("R6", "busy", busy, m_cnt != 0);
            chk("R9", "pwr_down", pwr_down, m_cnt == 0);
            chk("R5", "done", done, m_done);
            chk("R4", "result", result, m_res);
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    // Start a conversion; optionally glitch the request mid-conversion (R7)
    task automatic convert(int unsigned code, int mode, int unsigned exp,
                           string tag, bit glitch);
        int n = 0;
        @(negedge clk);
        vin = code; cmode = mode; conv_req_n = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            n++;
            if (glitch && n == 5) conv_req_n = 1'b1;
            if (glitch && n == 7) conv_req_n = 1'b0;
            if (done) break;
        end
        chk(tag, "code", result, exp);
        chk("R5", "done latency", n, 18);
        // request still low: no retrigger
        repeat (3) @(negedge clk);
        chk("R11", "busy held-low", busy, 0);
        chk("R10", "result hold", result, exp);
        conv_req_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "samp_sw_closed", samp_sw_closed, 1);
        chk("R1", "arr_on_input", arr_on_input, 1);
        chk("R1", "bit_sw_ref", bit_sw_ref, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "pwr_down", pwr_down, 1);
        chk("R1", "result", result, 0);
        rst = 1'b0;
        @(negedge clk);
        convert(32'h8000, 0, 32'h8000, "R4", 0);
        convert(32'h7FFF, 0, 32'h7FFF, "R4", 0);
        convert(32'hFFFF, 0, 32'hFFFF, "R4", 0);
        convert(32'h0000, 0, 32'h0000, "R4", 0);
        convert(32'h0001, 0, 32'h0001, "R4", 0);
        convert(32'hA5C3, 0, 32'hA5C3, "R4", 0);
        convert(32'h0000, 1, 32'hFFFF, "R8", 0);
        convert(32'hFFFF, 2, 32'h0000, "R8", 0);
        convert(32'h1234, 0, 32'h1234, "R7", 1);
        convert(32'h5A5A, 0, 32'h5A5A, "R7", 1);
        repeat (2) @(negedge clk);
        summary();
    end
endmodule